// File: doc/BRIEF.md
# Timing State Sequencer

This block is a small programmable timing engine. It holds a table of state words and walks through them one at a time. Each word sets three things for its state: how long the state lasts, whether its length is counted in fast system-clock cycles or in strobes of a slower timebase, and which control lines are driven while it is active. Those lines are a DAC enable, an output-latch enable, a test-cycle select that picks one of two test channel sets, and a small channel field.

Software fills the table through a single-word write port while the engine is idle. A one-cycle `start` pulse launches a run at entry 0. A word with its stop flag set ends the run after exactly one fast cycle. A run that reaches the last entry without a stop also ends there. On completion the block gives a one-cycle `done` pulse and drops back to idle, where every control line is low.

The slower timebase arrives as an enable strobe in the system clock domain. A state paced by it advances its count only in cycles where the strobe is high.

Top module: `tstate_seq`

## Requirements
- R1: After reset every table word is 0, `busy`, `done` and `cur_state` are 0, and `latch_en`, `test_sel`, `test_ch`, `chan` are 0 (`dac_en` is 0 unless `dac_force` is 1). A run of the reset table therefore executes all entries as one-cycle fast states.
- R2: A `start` pulse seen while idle makes `busy` high with `cur_state` 0 in the next cycle. A `start` seen while `busy` is high has no effect on the run.
- R3: A state with bit 10 = 0 and bit 9 = 0 stays active for exactly (bits 15:11) + 1 clock cycles.
- R4: A state with bit 10 = 1 and bit 9 = 0 stays active until the cycle in which the ((bits 15:11) + 1)-th `slow_tick` strobe is seen, and ends on that cycle.
- R5: A state with bit 9 = 1 stays active for exactly one clock cycle, whatever bits 15:11 and 10 hold, and then the run ends.
- R6: When a non-stop state that is not the last entry expires, `cur_state` advances by one in the next cycle while `busy` stays high.
- R7: When entry N_STATES-1 expires without a stop flag, the run ends exactly as after a stop state.
- R8: The cycle after a run ends, `busy` is 0 and `done` is 1 for that single cycle. While idle, `cur_state` is 0 and `latch_en`, `test_sel`, `test_ch`, `chan` are 0.
- R9: With `dac_force` = 0, `dac_en` equals bit 8 of the active word while running and 0 while idle. With `dac_force` = 1, `dac_en` is 1 in every cycle.
- R10: While running, `test_sel` equals bit 7 of the active word, and `test_ch` is `tch1` when bit 7 is 1 and `tch0` when it is 0.
- R11: While running, `latch_en` equals bit 6 of the active word, and `chan` equals bits CH_W-1:0 of that word.
- R12: A table write issued while `busy` is high is dropped. A write to an address of N_STATES or above is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe of the slow timebase |
| start | input | 1 | Launch pulse for a run |
| dac_force | input | 1 | Holds `dac_en` high when 1 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW | Table entry to write |
| wr_data | input | 16 | State word to store |
| tch0 | input | CH_W | Test channel set used when bit 7 = 0 |
| tch1 | input | CH_W | Test channel set used when bit 7 = 1 |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after a run ends |
| cur_state | output | AW | Index of the active entry (0 when idle) |
| dac_en | output | 1 | DAC enable |
| latch_en | output | 1 | Output-latch enable |
| test_sel | output | 1 | Test-cycle select (0: set 0 and DAC register 6, 1: set 1 and DAC register 7) |
| test_ch | output | CH_W | Selected test channel set |
| chan | output | CH_W | Channel field of the active word |

## Verification
The first run uses the all-zero reset table. A correct block executes every entry for one cycle and ends at the last index, so this run exposes a broken end-of-table rule or a nonzero reset word. Fast states are then swept over all 32 repeat values with varied control bits, which separates off-by-one counting and wrong field positions. Slow-paced states are run under strobe periods of 1, 3 and 4 cycles, which separates counting strobes from counting cycles and shows where a state ends relative to its last strobe. Stop words that carry a large repeat value and slow pacing show whether the stop flag overrides both; forced-DAC runs, start and write pokes in mid-run, and out-of-range writes are each compared against the total run length of an undisturbed run.

// File: rtl/tstate_pkg.sv
package tstate_pkg;

   // Field layout of one state word; positions are fixed by the sequence format.
   localparam int REP_W  = 5;
   localparam int LINE_W = 6;

   typedef struct packed {
      logic [REP_W-1:0]  rep;    // 15:11 repeat count, duration = rep + 1
      logic              slow;   // 10    pace by slow strobe
      logic              stop;   // 9     final state, one fast cycle
      logic              dac;    // 8     DAC enable request
      logic              tsel;   // 7     test-cycle select
      logic              latch;  // 6     output-latch enable
      logic [LINE_W-1:0] line;   // 5:0   channel field (low CH_W bits used)
   } st_word_t;

   localparam int WORD_W = $bits(st_word_t);

endpackage

// File: rtl/tstate_regfile.sv
module tstate_regfile #(
   parameter int DEPTH  = 24,
   parameter int WORD_W = 16,
   parameter int AW     = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              lock,
   input  logic [AW-1:0]     rd_idx,
   output logic [WORD_W-1:0] rd_word
);

   localparam int SLOTS = 1 << AW;

   logic [WORD_W-1:0] slot_w [SLOTS];
   logic              wr_ok;

   assign wr_ok = wr_en && !lock;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < DEPTH) begin : g_live
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_ok && (wr_addr == AW'(i))) begin
               q <= wr_data;
            end
         end
         assign slot_w[i] = q;
      end else begin : g_hole
         assign slot_w[i] = '0;
      end
   end

   assign rd_word = slot_w[rd_idx];

endmodule

// File: rtl/tstate_dwell.sv
module tstate_dwell #(
   parameter int REP_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             slow_sel,
   input  logic             stop,
   input  logic [REP_W-1:0] rep,
   input  logic             slow_tick,
   output logic             expire
);

   logic [REP_W-1:0] cnt_q;
   logic             tick;

   assign tick   = slow_sel ? slow_tick : 1'b1;
   assign expire = run && (stop || (tick && (cnt_q == rep)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || expire) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/tstate_outdec.sv
module tstate_outdec
   import tstate_pkg::*;
#(
   parameter int CH_W = 2
)(
   input  logic            active,
   input  logic            dac_force,
   input  st_word_t        word,
   input  logic [CH_W-1:0] tch0,
   input  logic [CH_W-1:0] tch1,
   output logic            dac_en,
   output logic            latch_en,
   output logic            test_sel,
   output logic [CH_W-1:0] test_ch,
   output logic [CH_W-1:0] chan
);

   always_comb begin
      dac_en   = dac_force || (active && word.dac);
      latch_en = active && word.latch;
      test_sel = active && word.tsel;
      test_ch  = '0;
      chan     = '0;
      if (active) begin
         test_ch = word.tsel ? tch1 : tch0;
         chan    = word.line[CH_W-1:0];
      end
   end

   if (CH_W < LINE_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^word.line[LINE_W-1:CH_W];
   end

endmodule

// File: rtl/tstate_seq.sv
module tstate_seq
   import tstate_pkg::*;
#(
   parameter int  N_STATES = 24,
   parameter int  CH_W     = 2,
   localparam int AW       = (N_STATES > 1) ? $clog2(N_STATES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              start,
   input  logic              dac_force,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [CH_W-1:0]   tch0,
   input  logic [CH_W-1:0]   tch1,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     cur_state,
   output logic              dac_en,
   output logic              latch_en,
   output logic              test_sel,
   output logic [CH_W-1:0]   test_ch,
   output logic [CH_W-1:0]   chan
);

   localparam logic [AW-1:0] LAST_IDX = AW'(N_STATES - 1);

   if (N_STATES < 2) begin : g_bad_depth
      $error("tstate_seq: N_STATES must be at least 2");
   end
   if ((CH_W < 1) || (CH_W > LINE_W)) begin : g_bad_chan
      $error("tstate_seq: CH_W must lie in 1..LINE_W");
   end

   logic              busy_q;
   logic              done_q;
   logic [AW-1:0]     idx_q;
   logic [WORD_W-1:0] rd_word;
   st_word_t          cur_word;
   logic              expire;
   logic              launch;
   logic              finish;

   tstate_regfile #(
      .DEPTH  (N_STATES),
      .WORD_W (WORD_W),
      .AW     (AW)
   ) u_regfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .lock    (busy_q),
      .rd_idx  (idx_q),
      .rd_word (rd_word)
   );

   assign cur_word = st_word_t'(rd_word);

   tstate_dwell #(
      .REP_W (REP_W)
   ) u_dwell (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_q),
      .slow_sel  (cur_word.slow),
      .stop      (cur_word.stop),
      .rep       (cur_word.rep),
      .slow_tick (slow_tick),
      .expire    (expire)
   );

   assign launch = !busy_q && start;
   assign finish = expire && (cur_word.stop || (idx_q == LAST_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (launch) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (finish) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else if (expire) begin
            idx_q  <= idx_q + 1'b1;
         end
      end
   end

   tstate_outdec #(
      .CH_W (CH_W)
   ) u_outdec (
      .active    (busy_q),
      .dac_force (dac_force),
      .word      (cur_word),
      .tch0      (tch0),
      .tch1      (tch1),
      .dac_en    (dac_en),
      .latch_en  (latch_en),
      .test_sel  (test_sel),
      .test_ch   (test_ch),
      .chan      (chan)
   );

   assign busy      = busy_q;
   assign done      = done_q;
   assign cur_state = idx_q;

endmodule

// File: rtl/tstate_seq_chk.sv
module tstate_seq_chk #(
   parameter int  N_STATES = 24,
   parameter int  CH_W     = 2,
   localparam int AW       = (N_STATES > 1) ? $clog2(N_STATES) : 1
)(
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            dac_force,
   input logic            busy,
   input logic            done,
   input logic [AW-1:0]   cur_state,
   input logic            dac_en,
   input logic            latch_en,
   input logic            test_sel,
   input logic [CH_W-1:0] test_ch,
   input logic [CH_W-1:0] chan
);

   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && (cur_state == '0)));

   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (cur_state != $past(cur_state)))
         |-> (cur_state == AW'($past(cur_state) + 1'b1)));

   p_done_follows_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!latch_en && !test_sel && (test_ch == '0) && (chan == '0)
                 && (cur_state == '0)));

   p_dac_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dac_force |-> dac_en);

   p_idle_dac_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !dac_force) |-> !dac_en);

endmodule

bind tstate_seq tstate_seq_chk #(
   .N_STATES (N_STATES),
   .CH_W     (CH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .dac_force (dac_force),
   .busy      (busy),
   .done      (done),
   .cur_state (cur_state),
   .dac_en    (dac_en),
   .latch_en  (latch_en),
   .test_sel  (test_sel),
   .test_ch   (test_ch),
   .chan      (chan)
);

// File: tb/tstate_seq_bench.sv
module tstate_seq_bench;
   localparam int N  = 24;
   localparam int CW = 2;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, start = 1'b0;
   logic          dac_force = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [CW-1:0] tch0 = 2'd1, tch1 = 2'd2;
   logic          busy, done, dac_en, latch_en, test_sel;
   logic [AW-1:0] cur_state;
   logic [CW-1:0] test_ch, chan;

   int checks = 0, fails = 0, cyc = 0, div = 3;
   int tot0 = 0, tot1 = 0, tot2 = 0;
   logic [15:0] tbl [N];

   tstate_seq #(.N_STATES(N), .CH_W(CW)) u_tstate_seq (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .start(start),
      .dac_force(dac_force), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tch0(tch0), .tch1(tch1), .busy(busy), .done(done), .cur_state(cur_state),
      .dac_en(dac_en), .latch_en(latch_en), .test_sel(test_sel),
      .test_ch(test_ch), .chan(chan));

   always #5 clk = ~clk;

   initial forever begin
      @(posedge clk); #1;
      cyc++;
      slow_tick = ((cyc % div) == 0);
   end

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input int rep, input bit slow, input bit stop,
                                      input bit dac, input bit tsel, input bit latch,
                                      input int ch);
      return {5'(rep), slow, stop, dac, tsel, latch, 4'b0000, 2'(ch)};
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a < N) tbl[a] = d;
   endtask

   task automatic run_seq(input bit poke, output int tot);
      int idx = 0, n, s, e_dac, e_tst, e_lat;
      bit ended = 0, lastst;
      logic [15:0] w;
      string tg;
      tot = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!ended) begin
         w = tbl[idx]; n = 0; s = 0; lastst = 0; e_dac = 0; e_tst = 0; e_lat = 0;
         while (busy && (cur_state == AW'(idx)) && (n < 600)) begin
            if (dac_en !== (dac_force | w[8])) e_dac++;
            if (test_sel !== w[7] || test_ch !== (w[7] ? tch1 : tch0)) e_tst++;
            if (latch_en !== w[6] || chan !== w[1:0]) e_lat++;
            n++; lastst = slow_tick; s += int'(slow_tick);
            if (poke && idx == 1 && n == 1) begin
               start = 1'b1; wr_en = 1'b1; wr_addr = '0; wr_data = 16'h0200;
            end else begin
               start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
         end
         start = 1'b0; wr_en = 1'b0;
         tot += n;
         chk(e_dac, 0, $sformatf("R9 dac_en mismatches in entry %0d", idx));
         chk(e_tst, 0, $sformatf("R10 test select mismatches in entry %0d", idx));
         chk(e_lat, 0, $sformatf("R11 latch/chan mismatches in entry %0d", idx));
         if (w[9]) chk(n, 1, $sformatf("R5 stop entry %0d length", idx));
         else if (!w[10]) chk(n, int'(w[15:11]) + 1, $sformatf("R3 fast entry %0d length", idx));
         else begin
            chk(s, int'(w[15:11]) + 1, $sformatf("R4 slow entry %0d strobes", idx));
            chk(int'(lastst), 1, $sformatf("R4 slow entry %0d ends on strobe", idx));
         end
         if (w[9] || idx == N - 1) begin
            tg = w[9] ? "R5" : "R7";
            chk(int'(busy), 0, {tg, " busy low after final entry"});
            chk(int'(done), 1, "R8 done pulse after run");
            @(negedge clk);
            chk(int'(done), 0, "R8 done lasts one cycle");
            chk(int'({latch_en, test_sel, test_ch, chan, cur_state}), 0, "R8 idle outputs low");
            ended = 1;
         end else begin
            chk(int'(busy && cur_state == AW'(idx + 1)), 1,
                $sformatf("R6 advance from entry %0d", idx));
            idx++;
         end
      end
   endtask

   initial begin
      #1_500_000;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) tbl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(int'(busy), 0, "R1 busy after reset");
      chk(int'(done), 0, "R1 done after reset");
      chk(int'(cur_state), 0, "R1 cur_state after reset");
      chk(int'({dac_en, latch_en, test_sel, test_ch, chan}), 0, "R1 outputs after reset");
      // R1, R7: reset table runs every entry once
      run_seq(0, tot0);
      chk(tot0, N, "R1 reset table run length");

      // R3: repeat sweep 0..23 with varied control bits
      for (int i = 0; i < N; i++)
         wr(i, mk(i, 0, 0, i[0], i[1], i[2], i ^ (i >> 2)));
      run_seq(0, tot0);
      // R3: repeats 24..31, then stop that carries slow pacing and max repeat (R5)
      for (int i = 0; i < 8; i++)
         wr(i, mk(24 + i, 0, 0, i[1], i[0], ~i[0], i));
      wr(8, mk(31, 1, 1, 1, 0, 1, 3));
      run_seq(0, tot0);
      chk(tot0, 8 * 28 + 4 + 1, "R5 run length with stop at entry 8");

      // R4: slow states under several strobe periods
      for (int i = 0; i < 6; i++) wr(i, mk(i, 1, 0, i[0], i[1], 1, i));
      wr(6, mk(2, 0, 0, 1, 1, 0, 2));
      wr(7, mk(9, 0, 1, 0, 1, 1, 1));
      div = 3; run_seq(0, tot0);
      div = 4; run_seq(0, tot0);
      div = 1; run_seq(0, tot0);
      chk(tot0, 21 + 3 + 1, "R4 slow states with strobe every cycle");

      // R9: forced DAC in idle and during a run
      dac_force = 1'b1;
      @(negedge clk);
      chk(int'(dac_en), 1, "R9 dac_en forced while idle");
      run_seq(0, tot1);
      dac_force = 1'b0;
      @(negedge clk);
      chk(int'(dac_en), 0, "R9 dac_en low while idle");

      // R2, R12: start and write poked mid-run
      run_seq(0, tot0);
      run_seq(1, tot1);
      chk(tot1, tot0, "R2 mid-run start ignored");
      run_seq(0, tot2);
      chk(tot2, tot0, "R12 mid-run write dropped");
      chk(int'(tbl[0][9]), 0, "R12 shadow entry 0 has no stop");

      // R12: writes above the table are dropped
      for (int i = 0; i < N; i++) wr(i, mk(0, 0, 0, 0, 0, 0, i));
      for (int i = N; i < (1 << AW); i++) wr(i, 16'h0200);
      run_seq(0, tot0);
      chk(tot0, N, "R12 out-of-range writes leave table intact");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule